// File: doc/BRIEF.md
# Gated 16-bit Auto-Reload Timer

This block is a 16-bit up-counter with a 16-bit reload value, controlled and observed through a byte-wide register bus. The bus has an address, a write strobe, write data and combinational read data. The counter advances on one of two sources. In timer mode it uses a tick from an internal prescaler, which marks one machine cycle. In counter mode it uses falling edges of an external count pin. The count pin is brought through a two-flop synchroniser and sampled once per machine cycle.

An optional gate lets an external level input hold the counter still while counting is enabled. When the count passes its all-ones value, it takes the reload value and sets an overflow flag. That flag drives the interrupt request line. An interrupt controller outside the block clears the flag with a one-cycle acknowledge strobe when it vectors. Software can also write the flag.

The control byte also stores the four external-interrupt configuration and status bits. The block only holds these bits so they can be read back.

Top module: `reload_timer16`

## Requirements
- R1: After reset, every mapped register reads 00h and `timer_irq` is low.
- R2: Register map: control at 88h, count low at 8Ah, reload low at 8Bh, count high at 8Ch, reload high at 8Dh. Any other address reads 00h. Control bits are [7] gate enable, [6] source select (1 = count pin), [5] overflow flag, [4] run, and [3:0] four stored external-interrupt bits that read back as written.
- R3: In timer mode (bit 6 = 0) with run set, the count rises by exactly one every PRESCALE clocks. The 16-bit value carries from the low byte into the high byte. The count pin has no effect in this mode.
- R4: In counter mode (bit 6 = 1) with run set, the count rises by one for each 1-to-0 transition of `count_pin`. The pin goes through a two-flop synchroniser and is sampled once per machine cycle, so each level must be held for at least two machine cycles.
- R5: With run clear, the count holds its value in both modes.
- R6: With gate enable set, counting happens only while `gate_pin` is high. A low gate stops the count even with run set.
- R7: An increment from FFFFh loads the count from the reload pair. The reload registers keep their values.
- R8: Overflow sets the flag (control bit 5), and `timer_irq` follows the flag.
- R9: A one-cycle `flag_ack` pulse clears the flag. Overflow in the same cycle takes precedence.
- R10: A control write sets or clears the flag according to bit 5 of the write data.
- R11: A write to either count byte in a cycle takes priority over an increment in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| count_pin | input | 1 | External count source, asynchronous |
| gate_pin | input | 1 | External gate level, asynchronous |
| flag_ack | input | 1 | One-cycle strobe that clears the overflow flag |
| timer_irq | output | 1 | Interrupt request, equal to the overflow flag |

## Verification
The bench builds the block with PRESCALE = 4 instead of the default 12. This makes a machine cycle four clocks, so multi-tick windows, counted edge trains and overflows fit in a few hundred cycles. Each count window is held open for an exact multiple of PRESCALE clock edges, so the expected count does not depend on the prescaler phase. Overflow and carry are reached by preloading the count to FFFEh and 00FEh rather than by counting through the full 16-bit range.

// File: rtl/grt_pkg.sv
// Shared constants and the control byte layout for the gated reload timer.
// Assumes a byte-wide register bus and a 16-bit count made of two bytes.
package grt_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [7:0] ADR_CTRL = 8'h88;
    localparam logic [7:0] ADR_CLO  = 8'h8A;
    localparam logic [7:0] ADR_RLO  = 8'h8B;
    localparam logic [7:0] ADR_CHI  = 8'h8C;
    localparam logic [7:0] ADR_RHI  = 8'h8D;

    localparam int B_FLAG = 5;

    // Packed so that bit 7 is gate_en and bits 3:0 are the stored interrupt bits.
    typedef struct packed {
        logic       gate_en;
        logic       src_ext;
        logic       flag;
        logic       run;
        logic [3:0] xint;
    } ctrl_t;
endpackage

// File: rtl/grt_tick_gen.sv
// Machine-cycle tick generator: one-clock pulse every PRESCALE clocks.
// Assumes PRESCALE >= 1; the phase restarts at reset.
module grt_tick_gen #(
    parameter int PRESCALE = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] pre_q;

    assign tick = (pre_q == LAST);

    // Free-running prescale counter, wraps on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= LAST);

    generate
        if (PRESCALE > 1) begin : g_spacing
            a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/grt_pin_sample.sv
// Synchronises the count and gate pins, and detects a falling edge on the
// count pin by sampling once per machine cycle. Assumes asynchronous pins.
module grt_pin_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cnt_pin,
    input  logic gate_pin,
    output logic cnt_fall,
    output logic gate_lvl
);
    logic cnt_s1, cnt_s2, gate_s1, gate_s2, prev_q;

    // Two-flop synchronisers for both pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cnt_s2, cnt_s1}   <= 2'b00;
            {gate_s2, gate_s1} <= 2'b00;
        end else begin
            {cnt_s2, cnt_s1}   <= {cnt_s1, cnt_pin};
            {gate_s2, gate_s1} <= {gate_s1, gate_pin};
        end
    end

    // Count-pin level as seen at the previous machine-cycle sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b0;
        else if (tick) prev_q <= cnt_s2;
    end

    assign cnt_fall = tick & prev_q & ~cnt_s2;
    assign gate_lvl = gate_s2;

    a_r4_fall_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_fall |-> tick);
endmodule

// File: rtl/grt_count.sv
// 16-bit count register pair with byte writes, increment and auto-reload.
// Assumes that increments arrive as single-cycle enables.
module grt_count
    import grt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  reload,
    output logic [CNT_W-1:0]  cnt_q,
    output logic             ovf
);
    logic wr_any;
    logic at_max;

    assign wr_any = wr_lo | wr_hi;
    assign at_max = &cnt_q;
    assign ovf    = inc & ~wr_any & at_max;

    // Count update: bus write first, then reload on wrap, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_any) begin
            if (wr_lo) cnt_q[BYTE_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wdata;
        end else if (ovf) begin
            cnt_q <= reload;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> cnt_q[BYTE_W-1:0] == $past(wdata));
    a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt_q == $past(reload));
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_any) |=> $stable(cnt_q));
endmodule

// File: rtl/grt_regs.sv
// Control byte, reload pair, overflow flag and the read-data multiplexer.
// Flag precedence: overflow sets, then a control write, then an acknowledge clears.
module grt_regs
    import grt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ovf,
    input  logic              vec_ack,
    input  logic [CNT_W-1:0]  cnt_q,
    output logic [BYTE_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              wr_lo,
    output logic              wr_hi
);
    logic  wr_ctrl, wr_rlo, wr_rhi;
    ctrl_t wview;

    assign wr_ctrl = we && (addr == ADR_CTRL);
    assign wr_lo   = we && (addr == ADR_CLO);
    assign wr_hi   = we && (addr == ADR_CHI);
    assign wr_rlo  = we && (addr == ADR_RLO);
    assign wr_rhi  = we && (addr == ADR_RHI);
    assign wview   = ctrl_t'(wdata);

    // Control byte and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.gate_en <= wview.gate_en;
                ctrl_q.src_ext <= wview.src_ext;
                ctrl_q.run     <= wview.run;
                ctrl_q.xint    <= wview.xint;
            end
            if (ovf)          ctrl_q.flag <= 1'b1;
            else if (wr_ctrl) ctrl_q.flag <= wview.flag;
            else if (vec_ack) ctrl_q.flag <= 1'b0;
        end
    end

    // Reload pair, written only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
        end else begin
            if (wr_rlo) reload_q[BYTE_W-1:0]     <= wdata;
            if (wr_rhi) reload_q[CNT_W-1:BYTE_W] <= wdata;
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        case (addr)
            ADR_CTRL: rdata = ctrl_q;
            ADR_CLO:  rdata = cnt_q[BYTE_W-1:0];
            ADR_CHI:  rdata = cnt_q[CNT_W-1:BYTE_W];
            ADR_RLO:  rdata = reload_q[BYTE_W-1:0];
            ADR_RHI:  rdata = reload_q[CNT_W-1:BYTE_W];
            default:  rdata = '0;
        endcase
    end

    a_r8_flag_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ctrl_q.flag);
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !ovf && !wr_ctrl) |=> !ctrl_q.flag);
    a_r10_sw_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !ovf) |=> ctrl_q.flag == $past(wdata[B_FLAG]));
    a_r7_reload_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_rlo && !wr_rhi) |=> $stable(reload_q));
endmodule

// File: rtl/reload_timer16.sv
// Top of the gated 16-bit auto-reload timer. It combines the prescaler, pin
// sampling, count pair and register file, and builds the increment enable.
// Assumes both pins are asynchronous and that flag_ack is a single-cycle strobe.
module reload_timer16
    import grt_pkg::*;
#(
    parameter int PRESCALE = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       count_pin,
    input  logic       gate_pin,
    input  logic       flag_ack,
    output logic       timer_irq
);
    logic             tick, cnt_fall, gate_lvl, inc, ovf, wr_lo, wr_hi;
    logic             src_ok, gate_ok;
    logic [CNT_W-1:0] cnt_q, reload_q;
    ctrl_t            ctrl_q;

    grt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    grt_pin_sample u_pins (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cnt_pin(count_pin), .gate_pin(gate_pin),
        .cnt_fall(cnt_fall), .gate_lvl(gate_lvl)
    );

    // Increment enable: source selection, run bit and gate qualification.
    always_comb begin
        src_ok  = ctrl_q.src_ext ? cnt_fall : tick;
        gate_ok = ~ctrl_q.gate_en | gate_lvl;
        inc     = src_ok & ctrl_q.run & gate_ok;
    end

    grt_count u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(reg_wdata),
        .reload(reload_q), .cnt_q(cnt_q), .ovf(ovf)
    );

    grt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we),
        .wdata(reg_wdata), .ovf(ovf), .vec_ack(flag_ack), .cnt_q(cnt_q),
        .rdata(reg_rdata), .ctrl_q(ctrl_q), .reload_q(reload_q),
        .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    assign timer_irq = ctrl_q.flag;

    a_r5_stopped_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.run |-> !ovf);
    a_r6_gate_low_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.gate_en && !gate_lvl) |-> !ovf);
endmodule

// File: tb/reload_timer16_tb_top.sv
// Directed bench for reload_timer16, built with PRESCALE = 4.
module reload_timer16_tb_top;
    localparam int P = 4;
    localparam logic [7:0] A_CTRL = 8'h88, A_CLO = 8'h8A, A_RLO = 8'h8B,
                           A_CHI = 8'h8C, A_RHI = 8'h8D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       count_pin = 1'b1;
    logic       gate_pin = 1'b0;
    logic       flag_ack = 1'b0;
    logic       timer_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    reload_timer16 #(.PRESCALE(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_pin(count_pin),
        .gate_pin(gate_pin), .flag_ack(flag_ack), .timer_irq(timer_irq)
    );

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(A_CLO, lo);
        rd(A_CHI, hi);
        v = {hi, lo};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(A_CLO, v[7:0]);
        wr(A_CHI, v[15:8]);
    endtask

    // Keep ctrl_val for exactly 'edges' clock edges, then stop while keeping the flag.
    task automatic run_window(input logic [7:0] ctrl_val, input int edges, input bit toggle);
        wr(A_CTRL, ctrl_val);
        for (int i = 0; i < edges - 1; i++) begin
            @(posedge clk);
            if (toggle && (i % 3 == 0)) count_pin <= ~count_pin;
        end
        @(negedge clk);
        reg_addr = A_CTRL; reg_we = 1'b1; reg_wdata = {2'b00, timer_irq, 5'b0};
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(A_CTRL, d); check(d, 8'h00, "R1 ctrl");
        rd(A_CLO, d);  check(d, 8'h00, "R1 count low");
        rd(A_CHI, d);  check(d, 8'h00, "R1 count high");
        rd(A_RLO, d);  check(d, 8'h00, "R1 reload low");
        rd(A_RHI, d);  check(d, 8'h00, "R1 reload high");
        check(timer_irq, 0, "R1 irq");
    endtask

    task automatic t_regmap;
        logic [7:0] d;
        wr(A_CTRL, 8'h0F);
        rd(A_CTRL, d); check(d, 8'h0F, "R2 xint bits");
        wr(A_RLO, 8'hA5);
        rd(A_RLO, d); check(d, 8'hA5, "R2 reload low");
        rd(8'h89, d); check(d, 8'h00, "R2 unmapped");
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_timer;
        int v;
        set_cnt(16'h00FE);
        run_window(8'h10, 5 * P, 1'b1);
        rd_cnt(v); check(v, 16'h0103, "R3 timer count and carry");
    endtask

    task automatic t_stopped;
        int v;
        set_cnt(16'h0040);
        run_window(8'h00, 10 * P, 1'b0);
        run_window(8'h40, 10 * P, 1'b1);
        rd_cnt(v); check(v, 16'h0040, "R5 run clear holds");
    endtask

    task automatic t_counter;
        int v;
        set_cnt(16'h0000);
        count_pin = 1'b1;
        wr(A_CTRL, 8'h50);
        repeat (4 * P) @(posedge clk);
        for (int k = 0; k < 5; k++) begin
            count_pin = 1'b0; repeat (3 * P) @(posedge clk);
            count_pin = 1'b1; repeat (3 * P) @(posedge clk);
        end
        wr(A_CTRL, 8'h00);
        rd_cnt(v); check(v, 5, "R4 counted falling edges");
    endtask

    task automatic t_gate;
        int v;
        set_cnt(16'h0000);
        gate_pin = 1'b0;
        repeat (5) @(posedge clk);
        run_window(8'h90, 8 * P, 1'b0);
        rd_cnt(v); check(v, 0, "R6 gate low blocks");
        gate_pin = 1'b1;
        repeat (5) @(posedge clk);
        run_window(8'h90, 8 * P, 1'b0);
        rd_cnt(v); check(v, 8, "R6 gate high counts");
        gate_pin = 1'b0;
    endtask

    task automatic t_overflow;
        int v;
        logic [7:0] d;
        wr(A_RLO, 8'h34); wr(A_RHI, 8'h12);
        set_cnt(16'hFFFE);
        run_window(8'h10, 3 * P, 1'b0);
        rd_cnt(v); check(v, 16'h1235, "R7 reload after wrap");
        rd(A_RLO, d); check(d, 8'h34, "R7 reload low kept");
        rd(A_RHI, d); check(d, 8'h12, "R7 reload high kept");
        rd(A_CTRL, d); check(d, 8'h20, "R8 flag set");
        check(timer_irq, 1, "R8 irq high");
    endtask

    task automatic t_ack;
        logic [7:0] d;
        @(negedge clk); flag_ack = 1'b1;
        @(negedge clk); flag_ack = 1'b0;
        check(timer_irq, 0, "R9 ack clears irq");
        rd(A_CTRL, d); check(d, 8'h00, "R9 ack clears flag");
    endtask

    task automatic t_swflag;
        logic [7:0] d;
        wr(A_CTRL, 8'h20);
        check(timer_irq, 1, "R10 software set");
        rd(A_CTRL, d); check(d, 8'h20, "R10 flag readback");
        wr(A_CTRL, 8'h00);
        check(timer_irq, 0, "R10 software clear");
    endtask

    task automatic t_wr_priority;
        bit ok = 1'b1;
        wr(A_CTRL, 8'h10);
        @(negedge clk);
        reg_addr = A_CLO; reg_we = 1'b1; reg_wdata = 8'h50;
        for (int i = 0; i < 3 * P; i++) begin
            @(posedge clk);
            @(negedge clk);
            #1 if (reg_rdata !== 8'h50) ok = 1'b0;
        end
        reg_we = 1'b0;
        check(ok, 1, "R11 write beats increment");
        wr(A_CTRL, 8'h00);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_timer();
        t_stopped();
        t_counter();
        t_gate();
        t_overflow();
        t_ack();
        t_swflag();
        t_wr_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule